// File: doc/BRIEF.md
# Interrupt Acceptance and Processor Status Flags

This block holds the status flag word of a processor core and decides, every cycle, whether a pending maskable interrupt request is taken. The word has these fields: a register bank choice, an arithmetic overflow flag, an interrupt enable, a stack pointer choice, two floating-point exception flags, a fixed-point designation bit, a rounding mode and a 3-bit processor priority level. The surrounding core updates these fields through arithmetic and floating-point status strobes and through a full-word write port. It reads them back as one word, along with dedicated bank and stack selects.

A request is taken only when interrupts are enabled and the request level is strictly above the current priority level. Taking a request clears the enable and switches to the interrupt stack. A software interrupt with a low vector number also switches to the interrupt stack. Decode, vector fetch and context saving belong to other blocks.

Top module: `irq_status_core`

## Requirements
- R1: `irq_take` is 1 in a cycle exactly when `irq_req` is 1, the enable bit (bit 2 of `flag_word`) is 1 and `irq_lvl` is strictly greater than the priority level (bits 11:9 of `flag_word`); it is combinational in that cycle.
- R2: While the priority level is 7, `irq_take` stays 0 for every request level.
- R3: After a cycle with `irq_take` = 1, the enable bit reads 0. Because of this, `irq_take` never lasts more than one clock.
- R4: After a cycle with `irq_take` = 1, the stack select (bit 3 of `flag_word`, also `stk_sel`) reads 0.
- R5: A cycle with `swi_valid` = 1 and `swi_num` below 128 leaves the stack select at 0. A number of 128 or above leaves the stack select unchanged.
- R6: `bank_sel` follows bit 0 of `flag_word`, and `stk_sel` follows bit 3. A write of 1 there gives 1 on these outputs one cycle later.
- R7: On a cycle with `alu_upd` = 1, bit 1 takes the value of `alu_ovf`. Without `alu_upd`, bit 1 holds its value.
- R8: On a cycle with `fpu_upd` = 1, bit 4 becomes `fpu_unf | fpu_subn` and bit 5 becomes `fpu_ovf | fpu_subn`.
- R9: A write (`wr_en` = 1) loads bits 11:0 from `wr_data`: bit 6 is the fixed-point designation and bits 8:7 are the rounding mode. Bits 15:12 always read 0, whatever value was written to them.
- R10: After reset, `flag_word`, `irq_take`, `bank_sel` and `stk_sel` are all 0.
- R11: When a write coincides with an accept, the enable and stack select end at 0 and every other field comes from the write. When a write coincides with a status strobe, the write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Maskable interrupt pending |
| irq_lvl | input | 3 | Priority level of the pending request |
| swi_valid | input | 1 | Software interrupt executes this cycle |
| swi_num | input | 8 | Software interrupt number |
| alu_upd | input | 1 | Arithmetic status update strobe |
| alu_ovf | input | 1 | Overflow result of that operation |
| fpu_upd | input | 1 | Floating-point status update strobe |
| fpu_unf | input | 1 | Floating-point underflow result |
| fpu_ovf | input | 1 | Floating-point overflow result |
| fpu_subn | input | 1 | A floating-point operand was subnormal |
| wr_en | input | 1 | Flag word write strobe |
| wr_data | input | 16 | Flag word write value |
| irq_take | output | 1 | Interrupt accepted this cycle |
| bank_sel | output | 1 | Selected register bank |
| stk_sel | output | 1 | Stack select: 0 interrupt stack, 1 user stack |
| flag_word | output | 16 | Full flag word |

## Verification
The overflow assertion assumes that an arithmetic strobe sees no write in the same cycle, since the write would take precedence. The stimulus keeps these two events apart, except in one collision test that is checked only at the ports. The accept-pulse assertions assume that the core may hold `irq_req` high across cycles. The bench does this on purpose, to show that the enable bit cleared by the accept stops a second pulse. The stack-select assertion relies on no other event raising that bit in the cycle after a low-numbered software interrupt. This holds because only a write can set the bit, and the software event takes priority over a write.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
   localparam int LVL_W  = 3;
   localparam int RND_W  = 2;
   localparam int USED_W = LVL_W + RND_W + 7;

   typedef struct packed {
      logic [LVL_W-1:0] lvl;
      logic [RND_W-1:0] rnd;
      logic             fixpt;
      logic             fp_ovf;
      logic             fp_unf;
      logic             stk;
      logic             ie;
      logic             ovf;
      logic             bank;
   } flags_t;
endpackage

// File: rtl/irqs_accept.sv
module irqs_accept #(
   parameter int LVL_W = 3
) (
   input  logic             req,
   input  logic [LVL_W-1:0] req_lvl,
   input  logic             ie,
   input  logic [LVL_W-1:0] cur_lvl,
   output logic             take
);
   localparam logic [LVL_W-1:0] TOP_LVL = {LVL_W{1'b1}};

   if (LVL_W < 1) begin : g_bad_lvl
      $error("irqs_accept: LVL_W must be at least 1");
   end

   logic above;
   logic blocked;

   always_comb begin
      above   = req_lvl > cur_lvl;
      blocked = cur_lvl == TOP_LVL;
      take    = req && ie && above && !blocked;
   end
endmodule

// File: rtl/irqs_swi_check.sv
module irqs_swi_check #(
   parameter int VEC_W     = 8,
   parameter int SWI_SPLIT = 128
) (
   input  logic             swi_valid,
   input  logic [VEC_W-1:0] swi_num,
   output logic             swi_clr
);
   localparam int SPLIT_LOG = (SWI_SPLIT > 1) ? $clog2(SWI_SPLIT) : 1;
   localparam bit IS_POW2   = (SWI_SPLIT > 1) && ((1 << SPLIT_LOG) == SWI_SPLIT);

   if (VEC_W < 1 || SWI_SPLIT < 1) begin : g_bad_cfg
      $error("irqs_swi_check: VEC_W and SWI_SPLIT must be positive");
   end

   if (SWI_SPLIT >= (1 << VEC_W)) begin : g_all
      assign swi_clr = swi_valid;
   end else if (IS_POW2) begin : g_pow2
      assign swi_clr = swi_valid && (swi_num[VEC_W-1:SPLIT_LOG] == '0);
   end else begin : g_cmp
      logic [VEC_W:0] limit;
      assign limit   = (VEC_W+1)'(SWI_SPLIT);
      assign swi_clr = swi_valid && ({1'b0, swi_num} < limit);
   end
endmodule

// File: rtl/irqs_flag_reg.sv
module irqs_flag_reg
   import irqs_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   alu_upd,
   input  logic   alu_ovf,
   input  logic   fpu_upd,
   input  logic   fpu_unf,
   input  logic   fpu_ovf,
   input  logic   fpu_subn,
   input  logic   wr_en,
   input  flags_t wr_flags,
   input  logic   swi_clr,
   input  logic   take,
   output flags_t q
);
   flags_t nxt;

   always_comb begin
      nxt = q;
      if (alu_upd) begin
         nxt.ovf = alu_ovf;
      end
      if (fpu_upd) begin
         nxt.fp_unf = fpu_unf | fpu_subn;
         nxt.fp_ovf = fpu_ovf | fpu_subn;
      end
      if (wr_en) begin
         nxt = wr_flags;
      end
      if (swi_clr) begin
         nxt.stk = 1'b0;
      end
      if (take) begin
         nxt.ie  = 1'b0;
         nxt.stk = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         q <= nxt;
      end
   end
endmodule

// File: rtl/irq_status_core.sv
module irq_status_core
   import irqs_pkg::*;
#(
   parameter int VEC_W     = 8,
   parameter int SWI_SPLIT = 128,
   parameter int FLAG_W    = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       irq_req,
   input  logic [irqs_pkg::LVL_W-1:0] irq_lvl,
   input  logic                       swi_valid,
   input  logic [VEC_W-1:0]           swi_num,
   input  logic                       alu_upd,
   input  logic                       alu_ovf,
   input  logic                       fpu_upd,
   input  logic                       fpu_unf,
   input  logic                       fpu_ovf,
   input  logic                       fpu_subn,
   input  logic                       wr_en,
   input  logic [FLAG_W-1:0]          wr_data,
   output logic                       irq_take,
   output logic                       bank_sel,
   output logic                       stk_sel,
   output logic [FLAG_W-1:0]          flag_word
);
   localparam int RSV_W = FLAG_W - USED_W;

   if (FLAG_W < USED_W) begin : g_bad_width
      $error("irq_status_core: FLAG_W too small for the flag fields");
   end

   flags_t cur;
   flags_t wr_flags;
   logic   swi_clr;

   assign wr_flags = flags_t'(wr_data[USED_W-1:0]);

   irqs_accept #(.LVL_W(LVL_W)) u_accept (
      .req     (irq_req),
      .req_lvl (irq_lvl),
      .ie      (cur.ie),
      .cur_lvl (cur.lvl),
      .take    (irq_take)
   );

   irqs_swi_check #(.VEC_W(VEC_W), .SWI_SPLIT(SWI_SPLIT)) u_swi (
      .swi_valid (swi_valid),
      .swi_num   (swi_num),
      .swi_clr   (swi_clr)
   );

   irqs_flag_reg u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .alu_upd  (alu_upd),
      .alu_ovf  (alu_ovf),
      .fpu_upd  (fpu_upd),
      .fpu_unf  (fpu_unf),
      .fpu_ovf  (fpu_ovf),
      .fpu_subn (fpu_subn),
      .wr_en    (wr_en),
      .wr_flags (wr_flags),
      .swi_clr  (swi_clr),
      .take     (irq_take),
      .q        (cur)
   );

   if (RSV_W > 0) begin : g_rsv
      assign flag_word = {{RSV_W{1'b0}}, cur};
   end else begin : g_norsv
      assign flag_word = cur;
   end

   assign bank_sel = cur.bank;
   assign stk_sel  = cur.stk;
endmodule

// File: rtl/irqs_checker.sv
module irqs_checker #(
   parameter int VEC_W     = 8,
   parameter int SWI_SPLIT = 128,
   parameter int FLAG_W    = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq_req,
   input logic [2:0]        irq_lvl,
   input logic              swi_valid,
   input logic [VEC_W-1:0]  swi_num,
   input logic              alu_upd,
   input logic              alu_ovf,
   input logic              wr_en,
   input logic              irq_take,
   input logic              stk_sel,
   input logic [FLAG_W-1:0] flag_word
);
   AST_TAKE_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |-> (irq_req && flag_word[2])); // R1
   AST_TAKE_ABOVE_LVL: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |-> (irq_lvl > flag_word[11:9])); // R1
   AST_TOP_LVL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_word[11:9] == 3'd7) |-> !irq_take); // R2
   AST_IE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |=> !flag_word[2]); // R3
   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |=> !irq_take); // R3
   AST_STK_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |=> !stk_sel); // R4
   AST_STK_ON_SWI: assert property (@(posedge clk) disable iff (!rst_n)
      (swi_valid && ({1'b0, swi_num} < (VEC_W+1)'(SWI_SPLIT))) |=> !stk_sel); // R5
   AST_OVF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_upd && !wr_en) |=> (flag_word[1] == $past(alu_ovf))); // R7
   AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      flag_word[FLAG_W-1:12] == '0); // R9
endmodule

bind irq_status_core irqs_checker #(
   .VEC_W(VEC_W), .SWI_SPLIT(SWI_SPLIT), .FLAG_W(FLAG_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_req   (irq_req),
   .irq_lvl   (irq_lvl),
   .swi_valid (swi_valid),
   .swi_num   (swi_num),
   .alu_upd   (alu_upd),
   .alu_ovf   (alu_ovf),
   .wr_en     (wr_en),
   .irq_take  (irq_take),
   .stk_sel   (stk_sel),
   .flag_word (flag_word)
);

// File: tb/irq_status_core_bench.sv
module irq_status_core_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_req = 1'b0;
   logic [2:0]  irq_lvl = '0;
   logic        swi_valid = 1'b0;
   logic [7:0]  swi_num = '0;
   logic        alu_upd = 1'b0;
   logic        alu_ovf = 1'b0;
   logic        fpu_upd = 1'b0;
   logic        fpu_unf = 1'b0;
   logic        fpu_ovf = 1'b0;
   logic        fpu_subn = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic        irq_take;
   logic        bank_sel;
   logic        stk_sel;
   logic [15:0] flag_word;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   irq_status_core u_irq_status_core (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_lvl(irq_lvl),
      .swi_valid(swi_valid), .swi_num(swi_num), .alu_upd(alu_upd),
      .alu_ovf(alu_ovf), .fpu_upd(fpu_upd), .fpu_unf(fpu_unf),
      .fpu_ovf(fpu_ovf), .fpu_subn(fpu_subn), .wr_en(wr_en),
      .wr_data(wr_data), .irq_take(irq_take), .bank_sel(bank_sel),
      .stk_sel(stk_sel), .flag_word(flag_word)
   );

   // {start word[11:0], request level, expected take}
   localparam logic [15:0] VECS [0:6] = '{
      {12'h00C, 3'd1, 1'b1},
      {12'h008, 3'd5, 1'b0},
      {12'h60C, 3'd3, 1'b0},
      {12'h60C, 3'd4, 1'b1},
      {12'hE0C, 3'd7, 1'b0},
      {12'hC0D, 3'd7, 1'b1},
      {12'h40C, 3'd1, 1'b0}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic write_word(input logic [15:0] w);
      @(negedge clk);
      wr_en = 1'b1; wr_data = w;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check("R10 word", 32'(flag_word), 0);
      check("R10 take", 32'(irq_take), 0);
      check("R10 bank", 32'(bank_sel), 0);
      check("R10 stk", 32'(stk_sel), 0);
      rst_n = 1'b1;

      // R1 R2 R3 R4 vector walk
      for (int i = 0; i < 7; i++) begin
         logic [11:0] w;
         logic [2:0]  l;
         logic        t;
         {w, l, t} = VECS[i];
         write_word({4'h0, w});
         irq_req = 1'b1; irq_lvl = l;
         #1;
         check($sformatf("R1/R2 take vec%0d", i), 32'(irq_take), 32'(t));
         @(negedge clk);
         irq_req = 1'b0;
         #1;
         check($sformatf("R3/R4 word vec%0d", i), 32'(flag_word),
               32'(t ? (w & 12'hFF3) : w));
      end

      // R3: held request produces a single pulse
      write_word(16'h0004);
      irq_req = 1'b1; irq_lvl = 3'd2;
      #1 check("R3 first cycle", 32'(irq_take), 1);
      @(negedge clk); #1;
      check("R3 second cycle", 32'(irq_take), 0);
      irq_req = 1'b0;

      // R6 outputs
      write_word(16'h0001);
      #1 check("R6 bank", 32'(bank_sel), 1);
      check("R6 stk low", 32'(stk_sel), 0);
      write_word(16'h0008);
      #1 check("R6 stk", 32'(stk_sel), 1);

      // R9 reserved bits
      write_word(16'hFFFF);
      #1 check("R9 rsv", 32'(flag_word), 32'h0FFF);
      write_word(16'h01C0);
      #1 check("R9 fixpt/rnd", 32'(flag_word), 32'h01C0);

      // R5 software interrupts
      write_word(16'h0008);
      swi_valid = 1'b1; swi_num = 8'd127;
      @(negedge clk); swi_valid = 1'b0;
      #1 check("R5 swi 127", 32'(stk_sel), 0);
      write_word(16'h0008);
      swi_valid = 1'b1; swi_num = 8'd128;
      @(negedge clk); swi_valid = 1'b0;
      #1 check("R5 swi 128", 32'(flag_word), 32'h0008);

      // R7 overflow
      write_word(16'h0000);
      alu_upd = 1'b1; alu_ovf = 1'b1;
      @(negedge clk); alu_upd = 1'b0; alu_ovf = 1'b0;
      #1 check("R7 set", 32'(flag_word), 32'h0002);
      @(negedge clk); #1;
      check("R7 hold", 32'(flag_word), 32'h0002);
      alu_upd = 1'b1;
      @(negedge clk); alu_upd = 1'b0;
      #1 check("R7 clear", 32'(flag_word), 32'h0000);

      // R8 floating-point flags
      fpu_upd = 1'b1; fpu_unf = 1'b1;
      @(negedge clk); fpu_unf = 1'b0;
      #1 check("R8 unf", 32'(flag_word), 32'h0010);
      fpu_ovf = 1'b1;
      @(negedge clk); fpu_ovf = 1'b0;
      #1 check("R8 ovf", 32'(flag_word), 32'h0020);
      fpu_subn = 1'b1;
      @(negedge clk); fpu_subn = 1'b0;
      #1 check("R8 subnormal", 32'(flag_word), 32'h0030);
      @(negedge clk); fpu_upd = 1'b0;
      #1 check("R8 clear", 32'(flag_word), 32'h0000);

      // R11 collisions
      write_word(16'h000C);
      wr_en = 1'b1; wr_data = 16'h01CF; irq_req = 1'b1; irq_lvl = 3'd3;
      #1 check("R11 take", 32'(irq_take), 1);
      @(negedge clk); wr_en = 1'b0; irq_req = 1'b0;
      #1 check("R11 write+take", 32'(flag_word), 32'h01C3);
      wr_en = 1'b1; wr_data = 16'h0000; alu_upd = 1'b1; alu_ovf = 1'b1;
      @(negedge clk); wr_en = 1'b0; alu_upd = 1'b0; alu_ovf = 1'b0;
      #1 check("R11 write+alu", 32'(flag_word), 32'h0000);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule